// File: doc/BRIEF.md
# Two-Wire Bus Bit Engine

This block is the bit and byte layer of a two-wire serial master. It runs from the system clock and accepts one primitive at a time: start, repeated start, stop, byte write, byte read that answers with ACK, and byte read that answers with NACK. A byte write returns the acknowledge level the slave gave. A byte read returns the received byte. Both bus lines are open drain. The block only pulls a line low or lets it go, and an external pull-up supplies the high level.

Each SCL period is split into four equal quarters. The length of a quarter is a count of system clocks on `cfg_qtr`. SDA changes only at the start of a quarter in which SCL is low. The incoming SDA level is sampled at the boundary between the two high quarters, which is the centre of the high phase. Ordering primitives into complete bus transactions is done by a sequencer above this block.

Top module: `twowire_bit_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, both `scl_pull` and `sda_pull` are 0 (both lines released) and `cmd_ready` is 1.
- R2: A start (`cmd_op` 0) pulls SDA low while SCL is high, then pulls SCL low. The engine then holds SCL low with SDA low until the next primitive.
- R3: Outside start and stop primitives, SDA changes only while SCL is low, so no spurious start or stop condition ever appears on the bus.
- R4: A stop (`cmd_op` 2) releases SCL while SDA is held low, then releases SDA while SCL is high. The engine then returns to idle with both lines released.
- R5: A byte write (`cmd_op` 3) sends `cmd_wdata` most significant bit first, one bit per SCL pulse, over 8 pulses. SDA is released for the ninth pulse.
- R6: A byte read (`cmd_op` 4 or 5) releases SDA for 8 pulses. On each pulse it shifts the sampled SDA level into the least significant bit of `rx_byte`.
- R7: On a byte write, the SDA level at the centre of the ninth high phase is stored in `ack_bit`; 0 means the slave acknowledged.
- R8: Each quarter of an SCL period lasts `cfg_qtr` system clocks, and a value of 0 counts as 1. Each high phase and each low phase of a data pulse therefore lasts 2·`cfg_qtr` clocks. `cfg_qtr` must exceed `SYNC_STAGES`.
- R9: Opcodes 6 and 7 are ignored, and so is any opcode other than 0 or 1 while the bus is idle. An ignored primitive raises no `done` and changes neither line.
- R10: On the ninth pulse of a read, opcode 4 pulls SDA low (ACK) during the low phase. Opcode 5 leaves SDA released (NACK).
- R11: A repeated start (`cmd_op` 1, or 0 issued while SCL is held low) first releases SDA while SCL is low, then releases SCL, then pulls SDA low after a quarter. This forms a fresh start condition.
- R12: `cmd_ready` is 1 whenever no primitive is running, and a primitive is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `done` is a one-cycle pulse at the end of each accepted primitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Primitive request valid |
| cmd_op | input | 3 | Primitive opcode (see R12 and R9) |
| cmd_wdata | input | DATA_W | Byte to send for a write |
| cfg_qtr | input | CNT_W | Quarter-period length in system clocks |
| sda_in | input | 1 | Sensed SDA line level |
| cmd_ready | output | 1 | Engine can take a primitive |
| done | output | 1 | One-cycle pulse when a primitive ends |
| rx_byte | output | DATA_W | Last byte read |
| ack_bit | output | 1 | Slave acknowledge level of the last write |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench models a slave on the open-drain bus and decodes SCL and SDA edges into start events, stop events and sampled bits. Write patterns include 0xA5, 0x3C, 0xFF, 0x01 and 0x81. Their alternating ends, all-ones and single-bit shapes separate MSB-first from LSB-first order and catch a missing release before the acknowledge pulse. Slave answers of both ACK and NACK separate a sampled `ack_bit` from a fixed one. Reads of 0x5A and 0xC3, closed with ACK and with NACK, check both the shift into the LSB and the level the master drives on the ninth pulse. Two quarter lengths show that the period follows `cfg_qtr`. A final count of start and stop events shows that no SDA edge happened while SCL was high outside those primitives.

// File: rtl/tw_pkg.sv
package tw_pkg;

   typedef enum logic [2:0] {
      OP_START   = 3'd0,
      OP_RSTART  = 3'd1,
      OP_STOP    = 3'd2,
      OP_WRITE   = 3'd3,
      OP_RD_ACK  = 3'd4,
      OP_RD_NACK = 3'd5
   } tw_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_RUN  = 2'd2
   } tw_state_e;

   typedef struct packed {
      logic scl_pull;
      logic sda_pull;
   } tw_drive_t;

   localparam int unsigned QTR_PER_BIT = 4;

endpackage

// File: rtl/tw_quarter_timer.sv
module tw_quarter_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cfg_qtr,
   output logic             qtick
);

   if (CNT_W < 2) begin : g_bad_width
      $error("tw_quarter_timer: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit_m1;

   // a zero setting behaves as a one-cycle quarter
   assign limit_m1 = (cfg_qtr == '0) ? '0 : (cfg_qtr - CNT_W'(1));
   assign qtick    = run && (cnt_q == limit_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || qtick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/tw_sda_sync.sv
module tw_sda_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("tw_sda_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign d_out = d_in;
   end else begin : g_chain
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe_q <= '1;
         end else begin
            pipe_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) begin
               pipe_q[i] <= pipe_q[i-1];
            end
         end
      end
      assign d_out = pipe_q[STAGES-1];
   end

endmodule

// File: rtl/tw_slot_decode.sv
module tw_slot_decode
   import tw_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int BIT_W = $clog2(DATA_W + 1)
) (
   input  tw_op_e           op,
   input  logic [BIT_W-1:0] bit_idx,
   input  logic [1:0]       qtr,
   input  logic             tx_msb,
   input  logic             scl_now,
   output tw_drive_t        drv,
   output logic [BIT_W-1:0] last_slot
);

   localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(DATA_W);

   logic high_half;
   logic data_slot;

   assign high_half = qtr[1];
   assign data_slot = (bit_idx < ACK_SLOT);

   always_comb begin
      drv       = '{scl_pull: 1'b0, sda_pull: 1'b0};
      last_slot = '0;
      unique case (op)
         OP_START, OP_RSTART: begin
            // q0 keeps SCL where it is while SDA is let go,
            // q1 raises SCL, q2 drops SDA, q3 drops SCL
            drv.scl_pull = (qtr == 2'd0) ? scl_now : (qtr == 2'd3);
            drv.sda_pull = high_half;
         end
         OP_STOP: begin
            drv.scl_pull = (qtr == 2'd0);
            drv.sda_pull = (qtr != 2'd3);
         end
         OP_WRITE: begin
            last_slot    = ACK_SLOT;
            drv.scl_pull = !high_half;
            drv.sda_pull = data_slot ? !tx_msb : 1'b0;
         end
         OP_RD_ACK: begin
            last_slot    = ACK_SLOT;
            drv.scl_pull = !high_half;
            drv.sda_pull = !data_slot;
         end
         OP_RD_NACK: begin
            last_slot    = ACK_SLOT;
            drv.scl_pull = !high_half;
            drv.sda_pull = 1'b0;
         end
         default: begin
            drv       = '{scl_pull: 1'b0, sda_pull: 1'b0};
            last_slot = '0;
         end
      endcase
   end

endmodule

// File: rtl/twowire_bit_engine.sv
module twowire_bit_engine
   import tw_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [CNT_W-1:0]  cfg_qtr,
   input  logic              sda_in,
   output logic              cmd_ready,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              ack_bit,
   output logic              scl_pull,
   output logic              sda_pull
);

   localparam int BIT_W = $clog2(DATA_W + 1);
   localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(DATA_W);

   if (DATA_W < 2) begin : g_bad_data
      $error("twowire_bit_engine: DATA_W must be at least 2");
   end
   if (QTR_PER_BIT != 4) begin : g_bad_qtr
      $error("twowire_bit_engine: quarter layout assumes four quarters");
   end

   tw_state_e         state_q;
   tw_op_e            op_q;
   logic [BIT_W-1:0]  bit_q;
   logic [1:0]        qtr_q;
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;
   logic              ack_q;
   logic              samp_q;
   logic              done_q;
   logic              scl_q;
   logic              sda_q;

   logic              qtick;
   logic              sda_s;
   tw_drive_t         drv;
   logic [BIT_W-1:0]  last_slot;
   logic              op_legal;
   logic              op_opens;
   logic              accept;
   logic              is_read;

   tw_quarter_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_RUN),
      .cfg_qtr (cfg_qtr),
      .qtick   (qtick)
   );

   tw_sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (sda_in),
      .d_out (sda_s)
   );

   tw_slot_decode #(.DATA_W(DATA_W)) u_decode (
      .op        (op_q),
      .bit_idx   (bit_q),
      .qtr       (qtr_q),
      .tx_msb    (tx_q[DATA_W-1]),
      .scl_now   (scl_q),
      .drv       (drv),
      .last_slot (last_slot)
   );

   assign op_legal  = (cmd_op <= 3'd5);
   assign op_opens  = (cmd_op == OP_START) || (cmd_op == OP_RSTART);
   assign cmd_ready = (state_q != ST_RUN);
   assign accept    = cmd_valid && cmd_ready && op_legal &&
                      ((state_q == ST_HOLD) || op_opens);
   assign is_read   = (op_q == OP_RD_ACK) || (op_q == OP_RD_NACK);

   // sequencing of quarters and slots
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_START;
         bit_q   <= '0;
         qtr_q   <= '0;
         tx_q    <= '0;
         done_q  <= 1'b0;
         samp_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         samp_q <= (state_q == ST_RUN) && qtick && (qtr_q == 2'd2);
         unique case (state_q)
            ST_IDLE, ST_HOLD: begin
               if (accept) begin
                  state_q <= ST_RUN;
                  op_q    <= tw_op_e'(cmd_op);
                  bit_q   <= '0;
                  qtr_q   <= '0;
                  tx_q    <= cmd_wdata;
               end
            end
            ST_RUN: begin
               if (qtick) begin
                  if (qtr_q == 2'd3) begin
                     qtr_q <= '0;
                     if (bit_q == last_slot) begin
                        state_q <= (op_q == OP_STOP) ? ST_IDLE : ST_HOLD;
                        done_q  <= 1'b1;
                     end else begin
                        bit_q <= bit_q + BIT_W'(1);
                        tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
                     end
                  end else begin
                     qtr_q <= qtr_q + 2'd1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // capture at the centre of the high phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q  <= '0;
         ack_q <= 1'b1;
      end else if (samp_q) begin
         if (is_read && (bit_q < ACK_SLOT)) begin
            rx_q <= {rx_q[DATA_W-2:0], sda_s};
         end
         if ((op_q == OP_WRITE) && (bit_q == ACK_SLOT)) begin
            ack_q <= sda_s;
         end
      end
   end

   // registered open-drain controls
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b0;
         sda_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               scl_q <= drv.scl_pull;
               sda_q <= drv.sda_pull;
            end
            ST_HOLD: scl_q <= 1'b1;
            default: begin
               scl_q <= 1'b0;
               sda_q <= 1'b0;
            end
         endcase
      end
   end

   assign done     = done_q;
   assign rx_byte  = rx_q;
   assign ack_bit  = ack_q;
   assign scl_pull = scl_q;
   assign sda_pull = sda_q;

endmodule

// File: rtl/twowire_bit_engine_chk.sv
module twowire_bit_engine_chk
   import tw_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      scl_pull,
   input logic      sda_pull,
   input logic      cmd_ready,
   input logic      done,
   input logic      qtick,
   input tw_state_e state,
   input tw_op_e    op
);

   // R3
   sda_fall_in_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_pull && $past(!scl_pull) && $rose(sda_pull))
         |-> (op == OP_START || op == OP_RSTART));

   // R3
   sda_rise_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_pull && $past(!scl_pull) && $fell(sda_pull))
         |-> (op == OP_STOP));

   // R1
   idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && $past(state == ST_IDLE))
         |-> (!scl_pull && !sda_pull && cmd_ready));

   // R8
   scl_on_quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scl_pull) |-> $past(qtick, 2));

   // R12
   done_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cmd_ready && !$past(done)));

endmodule

bind twowire_bit_engine twowire_bit_engine_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_pull  (scl_pull),
   .sda_pull  (sda_pull),
   .cmd_ready (cmd_ready),
   .done      (done),
   .qtick     (qtick),
   .state     (state_q),
   .op        (op_q)
);

// File: tb/twowire_bit_engine_tb_top.sv
module twowire_bit_engine_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [7:0] cmd_wdata = 8'h00;
   logic [15:0] cfg_qtr = 16'd3;
   logic       sda_in;
   logic       cmd_ready;
   logic       done;
   logic [7:0] rx_byte;
   logic       ack_bit;
   logic       scl_pull;
   logic       sda_pull;
   logic       slave_pull = 1'b0;

   int n_checks = 0;
   int n_errs = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   assign sda_in = !(sda_pull || slave_pull);

   twowire_bit_engine dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_wdata (cmd_wdata),
      .cfg_qtr   (cfg_qtr),
      .sda_in    (sda_in),
      .cmd_ready (cmd_ready),
      .done      (done),
      .rx_byte   (rx_byte),
      .ack_bit   (ack_bit),
      .scl_pull  (scl_pull),
      .sda_pull  (sda_pull)
   );

   // bus monitor
   logic prev_scl = 1'b1, prev_sda = 1'b1;
   int n_rise = 0, n_fall = 0, n_start = 0, n_stop = 0, n_done = 0;
   int hi_run = 0, hi_len = 0;
   logic [8:0] mon_sh = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!scl_pull && !prev_scl) begin
            n_rise <= n_rise + 1;
            mon_sh <= {mon_sh[7:0], sda_in};
         end
         if (scl_pull && prev_scl) n_fall <= n_fall + 1;
         if (!scl_pull && prev_scl && prev_sda && !sda_in) n_start <= n_start + 1;
         if (!scl_pull && prev_scl && !prev_sda && sda_in) n_stop <= n_stop + 1;
         if (!scl_pull) hi_run <= prev_scl ? hi_run + 1 : 1;
         if (scl_pull && prev_scl) hi_len <= hi_run;
         if (done) n_done <= n_done + 1;
      end
      prev_scl <= !scl_pull;
      prev_sda <= sda_in;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic issue(input logic [2:0] op, input logic [7:0] data);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op = op;
      cmd_wdata = data;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int w = 0;
      while (!done && w < 5000) begin
         @(negedge clk);
         w++;
      end
      check(done == 1'b1, {tag, " done pulse"}, done, 1);
      idle_n(3);
   endtask

   task automatic wait_falls(input int target);
      int w = 0;
      while (n_fall < target && w < 5000) begin
         @(negedge clk);
         w++;
      end
   endtask

   task automatic t_reset();
      check(scl_pull == 1'b0 && sda_pull == 1'b0, "R1 lines released after reset",
            {scl_pull, sda_pull}, 0);
      check(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
   endtask

   task automatic t_ignore_idle();
      int d0 = n_done;
      issue(3'd3, 8'hAA);   // R9 write while idle
      issue(3'd7, 8'h00);   // R9 reserved code
      idle_n(40);
      check(n_done == d0, "R9 no done for ignored ops in idle", n_done, d0);
      check(scl_pull == 1'b0 && sda_pull == 1'b0, "R9 lines untouched in idle",
            {scl_pull, sda_pull}, 0);
   endtask

   task automatic t_start(input logic [2:0] op, input string tag);
      int s0 = n_start;
      issue(op, 8'h00);
      wait_done(tag);
      check(n_start == s0 + 1, {tag, " start condition seen"}, n_start, s0 + 1);
      check(scl_pull == 1'b1 && sda_pull == 1'b1, {tag, " ends with both lines low"},
            {scl_pull, sda_pull}, 3);
   endtask

   task automatic t_write(input logic [7:0] b, input logic slv_ack, input int qtr);
      int f0 = n_fall;
      slave_pull = 1'b0;
      issue(3'd3, b);
      wait_falls(f0 + 8);
      slave_pull = (slv_ack == 1'b0);
      wait_done("R5 write");
      slave_pull = 1'b0;
      check(mon_sh[8:1] == b, "R5 bits on bus MSB first", mon_sh[8:1], b);
      check(ack_bit == slv_ack, "R7 sampled acknowledge", ack_bit, slv_ack);
      check(hi_len == 2 * qtr, "R8 high phase length", hi_len, 2 * qtr);
   endtask

   task automatic t_read(input logic [7:0] b, input logic give_ack);
      int f0 = n_fall;
      slave_pull = !b[7];
      issue(give_ack ? 3'd4 : 3'd5, 8'h00);
      for (int k = 1; k < 8; k++) begin
         wait_falls(f0 + k);
         slave_pull = !b[7-k];
      end
      wait_falls(f0 + 8);
      slave_pull = 1'b0;
      wait_done("R6 read");
      check(rx_byte == b, "R6 received byte", rx_byte, b);
      check(mon_sh[0] == !give_ack, "R10 master acknowledge level", mon_sh[0], !give_ack);
   endtask

   task automatic t_stop();
      int p0 = n_stop;
      issue(3'd2, 8'h00);
      wait_done("R4 stop");
      check(n_stop == p0 + 1, "R4 stop condition seen", n_stop, p0 + 1);
      check(scl_pull == 1'b0 && sda_pull == 1'b0 && cmd_ready,
            "R4 idle after stop", {scl_pull, sda_pull}, 0);
   endtask

   task automatic t_reserved_hold();
      int d0 = n_done;
      issue(3'd6, 8'h00);
      idle_n(40);
      check(n_done == d0, "R9 reserved op ignored while held", n_done, d0);
      check(scl_pull == 1'b1 && cmd_ready == 1'b1, "R9 SCL still held, ready",
            {scl_pull, cmd_ready}, 3);
   endtask

   initial begin
      idle_n(5);
      rst_n = 1'b1;
      idle_n(2);
      t_reset();
      t_ignore_idle();
      cfg_qtr = 16'd3;
      t_start(3'd0, "R2");
      t_write(8'hA5, 1'b0, 3);
      t_write(8'h3C, 1'b1, 3);
      t_write(8'hFF, 1'b0, 3);
      t_write(8'h01, 1'b0, 3);
      t_reserved_hold();
      t_read(8'h5A, 1'b1);
      t_start(3'd1, "R11");
      t_write(8'h81, 1'b0, 3);
      t_read(8'hC3, 1'b0);
      t_stop();
      cfg_qtr = 16'd7;
      t_start(3'd0, "R2");
      t_write(8'h69, 1'b1, 7);
      t_stop();
      // R3 no spurious start or stop events anywhere
      check(n_start == 3, "R3 total start events", n_start, 3);
      check(n_stop == 2, "R3 total stop events", n_stop, 2);
      check(cmd_ready == 1'b1, "R12 ready at end", cmd_ready, 1);
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errs++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
         $finish;
      end
   end

endmodule